// File: doc/BRIEF.md
# Write-Protect Register and Acknowledge Arbiter

This block sits beside the serial slave engine of a 256-byte nonvolatile array. It decides, for each byte of a transaction, whether the slave drives an acknowledge: the command byte that follows START, the word-address byte and every data byte. It also holds the software protection state of the lower half of the array. That state has two forms. One form can be removed again. The other, once it is committed, cannot be removed.

The slave engine reports events as single-cycle strobes: START, STOP, a received command byte, a received address byte, a received data byte. The block answers each strobe in the same cycle with a combinational acknowledge decision. When STOP closes a write that was accepted, the block raises a program-start strobe and stays busy until the program engine reports completion. At completion it commits the result: a memory-commit strobe for an array write, or a protect-commit strobe with an operation code for a protection change. Driving the protect pin high while the block is busy cancels the cycle and nothing is committed. The protection state is held in registers that model the nonvolatile cells.

Top module: `wp_ack_arbiter`

## Requirements
- R1: A command byte is decoded from bits [7:4] (device code) and bits [3:1] (select). Code 1010 with select equal to `strapAddr` is a memory command. Code 0110 with `hvOnA0` high and select 001 is set-protect. Code 0110 with `hvOnA0` high and select 011 is clear-protect. Code 0110 with select equal to `strapAddr` is permanent-protect. Any other byte is not acknowledged.
- R2: `cmdAck` follows the decoded command and the stored state. A memory command is always acknowledged. Set-protect is acknowledged only when no protection of either kind is active. Clear-protect and permanent-protect are acknowledged only when permanent protection is not active.
- R3: After an acknowledged command with bit 0 low (a write), the next address byte is acknowledged.
- R4: In the data phase a byte is acknowledged unless one of two conditions holds. The first is that `wpLevel` is high. The second is that the command is a memory write, the address is below 80h, and any protection is active.
- R5: A refused data byte ends the command: later bytes are refused and STOP starts no cycle. STOP raises `progStart` for one cycle only if the last data byte of the command was acknowledged.
- R6: From the cycle after `progStart` until the cycle is completed or aborted, `progBusy` is high and no command byte is acknowledged.
- R7: `progDone` with `wpLevel` low while busy ends the cycle. It pulses `memCommit` for a memory write. For a protection change it pulses `protCommit` with `protOp` set to 1 (set), 2 (clear) or 3 (permanent), and `protOp` is 0 at all other times.
- R8: `wpLevel` high while busy ends the cycle without any commit strobe and leaves the protection state unchanged.
- R9: A committed clear-protect removes set-protect protection. Permanent protection cannot be removed: after it, clear-protect is refused and the lower half stays write-protected.
- R10: After reset there is no protection, no cycle is pending and all outputs are low.
- R11: A command with bit 0 high (a read) is acknowledged by the R2 rule but opens no address or data phase: a following address byte is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startSeen | input | 1 | START condition strobe |
| stopSeen | input | 1 | STOP condition strobe |
| cmdValid | input | 1 | Command byte received strobe |
| cmdByte | input | 8 | Received command byte |
| hvOnA0 | input | 1 | High-voltage level detected on the lowest strap pin |
| strapAddr | input | 3 | Device select strap value |
| addrValid | input | 1 | Address byte received strobe |
| addrByte | input | 8 | Received word address |
| dataValid | input | 1 | Data byte received strobe |
| wpLevel | input | 1 | Hardware write-protect pin level |
| progDone | input | 1 | Program cycle finished |
| cmdAck | output | 1 | Acknowledge the command byte |
| addrAck | output | 1 | Acknowledge the address byte |
| dataAck | output | 1 | Acknowledge the data byte |
| progStart | output | 1 | Start a program cycle |
| progBusy | output | 1 | Program cycle in progress |
| memCommit | output | 1 | Array write completed, commit it |
| protCommit | output | 1 | Protection change completed |
| protOp | output | 2 | Protection change code with protCommit |

## Verification
The assertions rely on the slave engine raising at most one of the START, STOP, command, address and data strobes in any cycle. The bus framing makes these events exclusive, and one property checks this assumption. The stimulus keeps to it by driving one event per cycle from its tasks. `wpLevel` and `progDone` are levels, so the stimulus changes them freely. This puts abort and completion in the same cycle and lets program-done pulses arrive while the block is idle. The random mix makes permanent protection rare, so that most transactions run against the reversible states.

// File: rtl/wpa_pkg.sv
package wpa_pkg;

  // Decoded command; the two low bits of a protect kind double as its commit code.
  typedef enum logic [2:0] {
    K_NONE = 3'd0,
    K_SET  = 3'd1,
    K_CLR  = 3'd2,
    K_PERM = 3'd3,
    K_MEM  = 3'd4
  } cmdKind_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_ADDR,
    PH_DATA,
    PH_DEAD
  } phase_e;

  // Strobes from control to the datapath.
  typedef struct packed {
    logic latchKind;
    logic latchAddr;
    logic commitProt;
  } dpStrobe_t;

endpackage

// File: rtl/wpa_datapath.sv
module wpa_datapath
  import wpa_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter logic [3:0]  MEM_CODE  = 4'b1010,
  parameter logic [3:0]  PROT_CODE = 4'b0110,
  parameter logic [2:0]  SET_SEL   = 3'b001,
  parameter logic [2:0]  CLR_SEL   = 3'b011
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [7:0]        cmdByte,
  input  logic              hvOnA0,
  input  logic [2:0]        strapAddr,
  input  logic [ADDR_W-1:0] addrByte,
  input  logic              wpLevel,
  output cmdKind_e          kindNow,
  output cmdKind_e          kindQ,
  output logic              cmdAllowed,
  output logic              dataAllowed
);

  localparam logic [ADDR_W-1:0] HALF = ADDR_W'(1) << (ADDR_W - 1);

  logic [3:0] devCode;
  logic [2:0] selBits;
  logic       lowQ;
  logic       softQ;
  logic       permQ;

  assign devCode = cmdByte[7:4];
  assign selBits = cmdByte[3:1];

  // Command decode; the high-voltage selects win over the strap match.
  always_comb begin
    kindNow = K_NONE;
    if (devCode == MEM_CODE && selBits == strapAddr) begin
      kindNow = K_MEM;
    end else if (devCode == PROT_CODE) begin
      if (hvOnA0 && selBits == SET_SEL)      kindNow = K_SET;
      else if (hvOnA0 && selBits == CLR_SEL) kindNow = K_CLR;
      else if (selBits == strapAddr)         kindNow = K_PERM;
    end
  end

  always_comb begin
    unique case (kindNow)
      K_MEM:         cmdAllowed = 1'b1;
      K_SET:         cmdAllowed = !softQ && !permQ;
      K_CLR, K_PERM: cmdAllowed = !permQ;
      default:       cmdAllowed = 1'b0;
    endcase
  end

  assign dataAllowed = !wpLevel && !(kindQ == K_MEM && lowQ && (softQ || permQ));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      kindQ <= K_NONE;
      lowQ  <= 1'b0;
    end else begin
      if (strobe.latchKind) kindQ <= kindNow;
      if (strobe.latchAddr) lowQ  <= (addrByte < HALF);
    end
  end

  // Protection cells, changed only by a completed protect cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      softQ <= 1'b0;
      permQ <= 1'b0;
    end else if (strobe.commitProt) begin
      unique case (kindQ)
        K_SET:   softQ <= 1'b1;
        K_CLR:   softQ <= 1'b0;
        K_PERM:  permQ <= 1'b1;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/wpa_control.sv
module wpa_control
  import wpa_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startSeen,
  input  logic      stopSeen,
  input  logic      cmdValid,
  input  logic      rwBit,
  input  logic      addrValid,
  input  logic      dataValid,
  input  logic      wpLevel,
  input  logic      progDone,
  input  cmdKind_e  kindNow,
  input  cmdKind_e  kindQ,
  input  logic      cmdAllowed,
  input  logic      dataAllowed,
  output dpStrobe_t strobe,
  output logic      cmdAck,
  output logic      addrAck,
  output logic      dataAck,
  output logic      progStart,
  output logic      progBusy,
  output logic      memCommit,
  output logic      protCommit
);

  phase_e phaseQ;
  logic   armedQ;
  logic   busyQ;
  logic   commitOk;

  assign cmdAck     = cmdValid && !busyQ && kindNow != K_NONE && cmdAllowed;
  assign addrAck    = addrValid && !busyQ && phaseQ == PH_ADDR;
  assign dataAck    = dataValid && !busyQ && phaseQ == PH_DATA && dataAllowed;
  assign progStart  = stopSeen && !busyQ && armedQ;
  assign progBusy   = busyQ;
  assign commitOk   = busyQ && progDone && !wpLevel;
  assign memCommit  = commitOk && kindQ == K_MEM;
  assign protCommit = commitOk && kindQ != K_MEM;

  assign strobe.latchKind  = cmdAck && !rwBit;
  assign strobe.latchAddr  = addrAck;
  assign strobe.commitProt = protCommit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ <= PH_IDLE;
      armedQ <= 1'b0;
      busyQ  <= 1'b0;
    end else if (busyQ) begin
      if (wpLevel || progDone) busyQ <= 1'b0;
    end else if (stopSeen) begin
      busyQ  <= armedQ;
      armedQ <= 1'b0;
      phaseQ <= PH_IDLE;
    end else if (startSeen) begin
      armedQ <= 1'b0;
      phaseQ <= PH_IDLE;
    end else if (cmdValid) begin
      armedQ <= 1'b0;
      phaseQ <= (cmdAck && !rwBit) ? PH_ADDR : PH_IDLE;
    end else if (addrValid) begin
      if (phaseQ == PH_ADDR) phaseQ <= PH_DATA;
    end else if (dataValid && phaseQ == PH_DATA) begin
      armedQ <= dataAllowed;
      if (!dataAllowed) phaseQ <= PH_DEAD;
    end
  end

endmodule

// File: rtl/wp_ack_arbiter.sv
module wp_ack_arbiter
  import wpa_pkg::*;
#(
  parameter int         ADDR_W    = 8,
  parameter logic [3:0] MEM_CODE  = 4'b1010,
  parameter logic [3:0] PROT_CODE = 4'b0110,
  parameter logic [2:0] SET_SEL   = 3'b001,
  parameter logic [2:0] CLR_SEL   = 3'b011
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startSeen,
  input  logic              stopSeen,
  input  logic              cmdValid,
  input  logic [7:0]        cmdByte,
  input  logic              hvOnA0,
  input  logic [2:0]        strapAddr,
  input  logic              addrValid,
  input  logic [ADDR_W-1:0] addrByte,
  input  logic              dataValid,
  input  logic              wpLevel,
  input  logic              progDone,
  output logic              cmdAck,
  output logic              addrAck,
  output logic              dataAck,
  output logic              progStart,
  output logic              progBusy,
  output logic              memCommit,
  output logic              protCommit,
  output logic [1:0]        protOp
);

  dpStrobe_t strobe;
  cmdKind_e  kindNow;
  cmdKind_e  kindQ;
  logic      cmdAllowed;
  logic      dataAllowed;

  wpa_datapath #(
    .ADDR_W(ADDR_W), .MEM_CODE(MEM_CODE), .PROT_CODE(PROT_CODE),
    .SET_SEL(SET_SEL), .CLR_SEL(CLR_SEL)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmdByte(cmdByte),
    .hvOnA0(hvOnA0), .strapAddr(strapAddr), .addrByte(addrByte),
    .wpLevel(wpLevel), .kindNow(kindNow), .kindQ(kindQ),
    .cmdAllowed(cmdAllowed), .dataAllowed(dataAllowed)
  );

  wpa_control u_ctl (
    .clk(clk), .rstN(rstN), .startSeen(startSeen), .stopSeen(stopSeen),
    .cmdValid(cmdValid), .rwBit(cmdByte[0]), .addrValid(addrValid),
    .dataValid(dataValid), .wpLevel(wpLevel), .progDone(progDone),
    .kindNow(kindNow), .kindQ(kindQ), .cmdAllowed(cmdAllowed),
    .dataAllowed(dataAllowed), .strobe(strobe), .cmdAck(cmdAck),
    .addrAck(addrAck), .dataAck(dataAck), .progStart(progStart),
    .progBusy(progBusy), .memCommit(memCommit), .protCommit(protCommit)
  );

  assign protOp = protCommit ? kindQ[1:0] : 2'd0;

endmodule

// File: rtl/wpa_checker.sv
module wpa_checker (
  input logic       clk,
  input logic       rstN,
  input logic       startSeen,
  input logic       stopSeen,
  input logic       cmdValid,
  input logic       addrValid,
  input logic       dataValid,
  input logic       wpLevel,
  input logic       progDone,
  input logic       cmdAck,
  input logic       addrAck,
  input logic       dataAck,
  input logic       progStart,
  input logic       progBusy,
  input logic       memCommit,
  input logic       protCommit,
  input logic [1:0] protOp
);

  // Input assumption: bus events are exclusive.
  p_events_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({startSeen, stopSeen, cmdValid, addrValid, dataValid}));

  p_one_ack_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmdAck, addrAck, dataAck}));

  p_wp_refuses_data_r4: assert property (@(posedge clk) disable iff (!rstN)
    (dataValid && wpLevel) |-> !dataAck);

  p_start_when_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    progStart |-> (stopSeen && !progBusy));

  p_start_then_busy_r5: assert property (@(posedge clk) disable iff (!rstN)
    progStart |=> progBusy);

  p_busy_no_cmd_ack_r6: assert property (@(posedge clk) disable iff (!rstN)
    progBusy |-> !cmdAck);

  p_busy_holds_r6: assert property (@(posedge clk) disable iff (!rstN)
    (progBusy && !progDone && !wpLevel) |=> progBusy);

  p_commit_exclusive_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({memCommit, protCommit}));

  p_commit_cause_r7: assert property (@(posedge clk) disable iff (!rstN)
    (memCommit || protCommit) |-> (progBusy && progDone && !wpLevel));

  p_commit_ends_r7: assert property (@(posedge clk) disable iff (!rstN)
    (memCommit || protCommit) |=> !progBusy);

  p_op_only_with_commit_r7: assert property (@(posedge clk) disable iff (!rstN)
    (protCommit ? (protOp != 2'd0) : (protOp == 2'd0)));

  p_abort_r8: assert property (@(posedge clk) disable iff (!rstN)
    (progBusy && wpLevel) |=> !progBusy);

  p_abort_no_commit_r8: assert property (@(posedge clk) disable iff (!rstN)
    wpLevel |-> !(memCommit || protCommit));

endmodule

bind wp_ack_arbiter wpa_checker u_chk (.*);

// File: tb/sim_wp_ack_arbiter.sv
module sim_wp_ack_arbiter;

  localparam logic [2:0] STRAP = 3'b110;
  localparam logic [7:0] MEMW  = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] MEMR  = {4'b1010, STRAP, 1'b1};
  localparam logic [7:0] SETC  = {4'b0110, 3'b001, 1'b0};
  localparam logic [7:0] CLRC  = {4'b0110, 3'b011, 1'b0};
  localparam logic [7:0] PERMC = {4'b0110, STRAP, 1'b0};
  localparam int P_IDLE = 0, P_ADDR = 1, P_DATA = 2, P_DEAD = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic       startSeen = 0, stopSeen = 0, cmdValid = 0, addrValid = 0, dataValid = 0;
  logic [7:0] cmdByte = 0, addrByte = 0;
  logic       hvOnA0 = 0, wpLevel = 0, progDone = 0;
  logic       cmdAck, addrAck, dataAck, progStart, progBusy, memCommit, protCommit;
  logic [1:0] protOp;

  wp_ack_arbiter u0 (
    .clk(clk), .rstN(rstN), .startSeen(startSeen), .stopSeen(stopSeen),
    .cmdValid(cmdValid), .cmdByte(cmdByte), .hvOnA0(hvOnA0), .strapAddr(STRAP),
    .addrValid(addrValid), .addrByte(addrByte), .dataValid(dataValid),
    .wpLevel(wpLevel), .progDone(progDone), .cmdAck(cmdAck), .addrAck(addrAck),
    .dataAck(dataAck), .progStart(progStart), .progBusy(progBusy),
    .memCommit(memCommit), .protCommit(protCommit), .protOp(protOp)
  );

  int tests = 0;
  int fails = 0;

  // Reference model state.
  bit mSoft = 0, mPerm = 0, mBusy = 0, mArmed = 0, mLow = 0;
  int mPhase = P_IDLE, mKind = 0;
  logic lastCmd, lastAddr, lastData, lastStart, lastMem, lastProt;
  logic [1:0] lastOp;

  function automatic int kindOf(logic [7:0] cb, logic hv);
    if (cb[7:4] == 4'b1010 && cb[3:1] == STRAP) return 4;
    if (cb[7:4] == 4'b0110) begin
      if (hv && cb[3:1] == 3'b001) return 1;
      if (hv && cb[3:1] == 3'b011) return 2;
      if (cb[3:1] == STRAP) return 3;
    end
    return 0;
  endfunction

  function automatic bit cmdOk(int k);
    case (k)
      4:       return 1'b1;
      1:       return !mSoft && !mPerm;
      2, 3:    return !mPerm;
      default: return 1'b0;
    endcase
  endfunction

  task automatic want(string tag, logic [3:0] got, logic [3:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  // One clock: compare outputs against the model, then advance the model.
  task automatic step();
    int k;
    bit eCmd, eAddr, eData, eStart, eMem, eProt;
    logic [1:0] eOp;
    #1;
    k      = kindOf(cmdByte, hvOnA0);
    eCmd   = cmdValid && !mBusy && k != 0 && cmdOk(k);
    eAddr  = addrValid && !mBusy && mPhase == P_ADDR;
    eData  = dataValid && !mBusy && mPhase == P_DATA && !wpLevel &&
             !(mKind == 4 && mLow && (mSoft || mPerm));
    eStart = stopSeen && !mBusy && mArmed;
    eMem   = progDone && mBusy && !wpLevel && mKind == 4;
    eProt  = progDone && mBusy && !wpLevel && mKind != 4;
    eOp    = eProt ? 2'(mKind) : 2'd0;
    want("R1/R2 cmdAck", cmdAck, eCmd);
    want("R3/R11 addrAck", addrAck, eAddr);
    want("R4 dataAck", dataAck, eData);
    want("R5 progStart", progStart, eStart);
    want("R6/R8 progBusy", progBusy, mBusy);
    want("R7 memCommit", memCommit, eMem);
    want("R7 protCommit", protCommit, eProt);
    want("R7 protOp", protOp, eOp);
    lastCmd = cmdAck; lastAddr = addrAck; lastData = dataAck;
    lastStart = progStart; lastMem = memCommit; lastProt = protCommit; lastOp = protOp;
    @(posedge clk);
    if (mBusy) begin
      if (wpLevel || progDone) begin
        if (!wpLevel) begin
          if (mKind == 1) mSoft = 1;
          if (mKind == 2) mSoft = 0;
          if (mKind == 3) mPerm = 1;
        end
        mBusy = 0;
      end
    end else if (stopSeen) begin
      mBusy = mArmed; mArmed = 0; mPhase = P_IDLE;
    end else if (startSeen) begin
      mArmed = 0; mPhase = P_IDLE;
    end else if (cmdValid) begin
      mArmed = 0;
      if (eCmd && !cmdByte[0]) begin mPhase = P_ADDR; mKind = k; end
      else mPhase = P_IDLE;
    end else if (addrValid) begin
      if (mPhase == P_ADDR) begin mPhase = P_DATA; mLow = (addrByte < 8'h80); end
    end else if (dataValid && mPhase == P_DATA) begin
      mArmed = eData;
      if (!eData) mPhase = P_DEAD;
    end
    @(negedge clk);
    startSeen = 0; stopSeen = 0; cmdValid = 0; addrValid = 0; dataValid = 0; progDone = 0;
  endtask

  task automatic doStart(); startSeen = 1; step(); endtask
  task automatic doStop();  stopSeen = 1;  step(); endtask
  task automatic doCmd(logic [7:0] b, logic hv); cmdValid = 1; cmdByte = b; hvOnA0 = hv; step(); endtask
  task automatic doAddr(logic [7:0] a); addrValid = 1; addrByte = a; step(); endtask
  task automatic doData(); dataValid = 1; step(); endtask
  task automatic doIdle(logic done); progDone = done; step(); endtask

  task automatic writeTxn(logic [7:0] b, logic [7:0] a);
    doStart(); doCmd(b, 1'b1); doAddr(a); doData(); doStop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int seedVal;
    seedVal = int'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R10: reset outputs
    want("R10 busy", progBusy, 0);
    want("R10 start", progStart, 0);
    want("R10 commit", {memCommit, protCommit}, 0);
    rstN = 1;
    @(negedge clk);

    // R10: unprotected lower half accepts a write
    writeTxn(MEMW, 8'h10);
    want("R10 low write start", lastStart, 1);
    doIdle(1'b1);
    want("R7 mem commit", lastMem, 1);

    // R2/R7: set-protect
    writeTxn(SETC, 8'h00);
    doIdle(1'b1);
    want("R7 set op", lastOp, 1);
    doStart(); doCmd(MEMW, 1'b1); doAddr(8'h10); doData();
    want("R4 low refused", lastData, 0);
    doData();
    want("R5 later byte refused", lastData, 0);
    doStop();
    want("R5 no cycle", lastStart, 0);
    writeTxn(MEMW, 8'h90);
    want("R4 high half ok", lastStart, 1);
    doIdle(1'b1);
    doStart(); doCmd(SETC, 1'b1);
    want("R2 repeat set refused", lastCmd, 0);
    doStart(); doCmd({4'b0110, 3'b001, 1'b0}, 1'b0);
    want("R1 no hv refused", lastCmd, 0);

    // R8: aborted clear leaves protection in force
    writeTxn(CLRC, 8'h00);
    wpLevel = 1; doIdle(1'b1); wpLevel = 0;
    want("R8 abort no commit", lastProt, 0);
    want("R8 busy cleared", progBusy, 0);
    doStart(); doCmd(SETC, 1'b1);
    want("R8 state kept", lastCmd, 0);

    // R9: clear removes reversible protection
    writeTxn(CLRC, 8'h00);
    doIdle(1'b1);
    want("R7 clear op", lastOp, 2);
    writeTxn(MEMW, 8'h20);
    want("R9 cleared write ok", lastStart, 1);
    doIdle(1'b0); doIdle(1'b1);

    // R11: read command opens no address phase
    doStart(); doCmd(MEMR, 1'b0);
    want("R11 read cmd ack", lastCmd, 1);
    doAddr(8'h05);
    want("R11 no addr ack", lastAddr, 0);
    doStop();

    // Random mix
    for (int t = 0; t < 600; t++) begin
      logic [7:0] cb;
      int r;
      r = int'($urandom % 6);
      case (r)
        0, 1: cb = MEMW;
        2:    cb = SETC;
        3:    cb = CLRC;
        4:    cb = ($urandom % 40 == 0) ? PERMC : MEMR;
        default: cb = 8'($urandom);
      endcase
      wpLevel = ($urandom % 10 == 0);
      doStart();
      doCmd(cb, ($urandom % 4) != 0);
      doAddr(8'($urandom));
      for (int d = 0; d < int'(1 + $urandom % 3); d++) begin
        wpLevel = ($urandom % 12 == 0);
        doData();
      end
      if ($urandom % 5 == 0) doIdle(1'b1);
      doStop();
      while (mBusy) begin
        wpLevel = ($urandom % 16 == 0);
        doIdle(($urandom % 3) == 0);
      end
      wpLevel = 0;
    end

    // R9: permanent protection cannot be removed
    if (!mPerm) begin
      writeTxn(PERMC, 8'h00);
      doIdle(1'b1);
      want("R7 perm op", lastOp, 3);
    end
    doStart(); doCmd(CLRC, 1'b1);
    want("R9 clear refused", lastCmd, 0);
    doStart(); doCmd(MEMW, 1'b1); doAddr(8'h7F);
    want("R3 addr ack", lastAddr, 1);
    doData();
    want("R9 low locked", lastData, 0);
    doStop();
    wpLevel = 1;
    doStart(); doCmd(MEMW, 1'b1); doAddr(8'hF0); doData();
    want("R4 wp refuses", lastData, 0);
    doStop();
    wpLevel = 0;
    writeTxn(MEMW, 8'hF0);
    want("R4 upper ok", lastStart, 1);
    doIdle(1'b1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule